// File: doc/BRIEF.md
# Reset Supervisor with Dual Watchdogs

This block merges every reset request of the chip into one chip-wide reset pulse. It handles five sources:

- loss of the supply-good level;
- a debounced external active-low reset pin;
- a reset command strobe from the serial control port;
- a watchdog that expects regular process-data accesses on that port;
- a watchdog that the on-chip processor must kick.

It also keeps a small register that names the source of the most recent reset, so firmware can read why the chip restarted.

All time windows are counted in cycles of the calibrated system clock, and every window is a parameter:

- `PIN_FILTER_CYCLES` (N) sets the pin filter length.
- `SPI_WD_CYCLES` (S) sets the serial-port watchdog timeout.
- `CPU_WD_CYCLES` (C) sets the processor watchdog timeout.
- `PULSE_CYCLES` (P) sets the reset pulse length.

The supply-good input acts as the asynchronous power-on reset of the block itself. The serial-port watchdog can be switched off. The processor watchdog is always armed.

All inputs other than `supplyGood` are synchronous to `clk` and are sampled on its rising edge.

Top module: `reset_supervisor`

## Requirements
- R1: While `supplyGood` is low, `chipReset` is high and `resetCause` is 0 (power). After `supplyGood` returns, `chipReset` stays high for exactly P rising edges and then falls.
- R2: The pin filter works on consecutive edges that sample `extResetN` low. The N-th such edge raises `chipReset` and records cause 1 (pin). A low run of N-1 edges or fewer has no effect.
- R3: While `extResetN` keeps being sampled low after it has qualified, `chipReset` stays high. It falls P edges after the last low sample.
- R4: When `chipReset` is low, a `spiResetCmd` strobe raises `chipReset` at that edge and records cause 2 (SPI command). A strobe that arrives while `chipReset` is high is ignored.
- R5: With `spiWdEnable` high, the S-th consecutive edge outside reset with no `spiValidOp` raises `chipReset` with cause 3 (SPI watchdog). Any `spiValidOp` restarts the count.
- R6: With `spiWdEnable` low, the serial-port watchdog never resets the chip, and its count is held at zero.
- R7: The C-th consecutive edge outside reset with no `cpuKick` raises `chipReset` with cause 4 (processor watchdog). A kick restarts the count.
- R8: A reset raised by the command or by either watchdog lasts exactly P cycles (P >= 2).
- R9: Both watchdog counts are held at zero during a reset pulse. They start counting again from zero on the first edge after the pulse ends.
- R10: When several requests arrive on the same edge outside reset, the recorded cause follows a fixed priority: pin, then SPI command, then SPI watchdog, then processor watchdog.
- R11: `resetCause` changes only on the edge where `chipReset` rises. Only a power loss clears it. A pin qualifying during a pulse started by another source extends the pulse but keeps the recorded cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calibrated system clock |
| supplyGood | input | 1 | Supply-good level; low resets everything asynchronously |
| extResetN | input | 1 | External reset pin, active low, already synchronised |
| spiResetCmd | input | 1 | One-cycle strobe: reset command written over the serial port |
| spiValidOp | input | 1 | One-cycle strobe: a process-data opcode was accepted |
| cpuKick | input | 1 | One-cycle strobe: processor kicks its watchdog |
| spiWdEnable | input | 1 | Enables the serial-port watchdog |
| chipReset | output | 1 | Chip reset, active high |
| resetCause | output | 3 | Source of the last reset: 0 power, 1 pin, 2 SPI command, 3 SPI watchdog, 4 processor watchdog |

## Verification
The bench checks the exact edge at which each threshold fires.

- **Pin filter.** A pin low for N-1 edges must be ignored, while N edges must qualify. A filter that is off by one passes short glitches or needs an extra cycle.
- **Watchdog windows.** A command arriving during a pulse must not stretch the pulse, and the watchdogs must restart from zero once the pulse ends. A design that lets the counters run during reset fires a second reset too early.
- **Cause recording.** The bench aims same-edge collisions at the priority order. It also lets the pin qualify inside a command pulse, to catch a cause register that is overwritten when it must be kept.
- **Power loss.** A power loss in the middle of the run must clear the cause.

// File: rtl/reset_supervisor_pkg.sv
package reset_supervisor_pkg;

  typedef enum logic [2:0] {
    CAUSE_POWER   = 3'd0,
    CAUSE_PIN     = 3'd1,
    CAUSE_SPI_CMD = 3'd2,
    CAUSE_SPI_WD  = 3'd3,
    CAUSE_CPU_WD  = 3'd4
  } resetCause_e;

  localparam int NUM_TIMERS = 3;
  localparam int TMR_PIN    = 0;
  localparam int TMR_SPI    = 1;
  localparam int TMR_CPU    = 2;

  typedef struct packed {
    logic [NUM_TIMERS-1:0] timerClear;
    logic [NUM_TIMERS-1:0] timerCount;
    logic                  holdLoad;
    logic                  holdDec;
    logic                  causeLoad;
    resetCause_e           causeVal;
  } ctrlStrobes_t;

endpackage

// File: rtl/reset_supervisor_timer.sv
// Saturating window counter: atLast goes high once LIMIT-1 counted edges have passed.
module reset_supervisor_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic supplyGood,
  input  logic clear,
  input  logic count,
  output logic atLast
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cntQ;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      cntQ <= '0;
    end else if (clear) begin
      cntQ <= '0;
    end else if (count && (cntQ != LAST)) begin
      cntQ <= cntQ + W'(1);
    end
  end

  assign atLast = (cntQ == LAST);
endmodule

// File: rtl/reset_supervisor_dp.sv
module reset_supervisor_dp
  import reset_supervisor_pkg::*;
#(
  parameter int unsigned PIN_FILTER_CYCLES = 1000,
  parameter int unsigned SPI_WD_CYCLES     = 2650000,
  parameter int unsigned CPU_WD_CYCLES     = 6250000,
  parameter int unsigned PULSE_CYCLES      = 16
) (
  input  logic                  clk,
  input  logic                  supplyGood,
  input  ctrlStrobes_t          strobes,
  output logic [NUM_TIMERS-1:0] timerAtLast,
  output logic                  holdActive,
  output logic [2:0]            resetCause
);
  localparam int unsigned LIMITS [NUM_TIMERS] =
    '{PIN_FILTER_CYCLES, SPI_WD_CYCLES, CPU_WD_CYCLES};
  localparam int HW = $clog2(PULSE_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(PULSE_CYCLES);

  logic [HW-1:0] holdQ;
  resetCause_e   causeQ;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
    reset_supervisor_timer #(.LIMIT(LIMITS[i])) timer_i (
      .clk       (clk),
      .supplyGood(supplyGood),
      .clear     (strobes.timerClear[i]),
      .count     (strobes.timerCount[i]),
      .atLast    (timerAtLast[i])
    );
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      holdQ  <= HOLD_INIT;
      causeQ <= CAUSE_POWER;
    end else begin
      if (strobes.holdLoad) begin
        holdQ <= HOLD_INIT;
      end else if (strobes.holdDec) begin
        holdQ <= holdQ - HW'(1);
      end
      if (strobes.causeLoad) begin
        causeQ <= strobes.causeVal;
      end
    end
  end

  assign holdActive = (holdQ != '0);
  assign resetCause = causeQ;
endmodule

// File: rtl/reset_supervisor_ctrl.sv
module reset_supervisor_ctrl
  import reset_supervisor_pkg::*;
(
  input  logic                  extResetN,
  input  logic                  spiResetCmd,
  input  logic                  spiValidOp,
  input  logic                  cpuKick,
  input  logic                  spiWdEnable,
  input  logic [NUM_TIMERS-1:0] timerAtLast,
  input  logic                  holdActive,
  output ctrlStrobes_t          strobes
);
  logic idle, pinLow, pinReq, cmdReq, spiWdReq, cpuWdReq, anyReq;

  always_comb begin
    idle     = !holdActive;
    pinLow   = !extResetN;
    pinReq   = pinLow && timerAtLast[TMR_PIN];
    cmdReq   = idle && spiResetCmd;
    spiWdReq = idle && spiWdEnable && !spiValidOp && timerAtLast[TMR_SPI];
    cpuWdReq = idle && !cpuKick && timerAtLast[TMR_CPU];
    anyReq   = pinReq || cmdReq || spiWdReq || cpuWdReq;

    strobes = '0;
    strobes.timerClear[TMR_PIN] = !pinLow;
    strobes.timerCount[TMR_PIN] = pinLow;
    strobes.timerClear[TMR_SPI] = holdActive || !spiWdEnable || spiValidOp;
    strobes.timerCount[TMR_SPI] = !strobes.timerClear[TMR_SPI];
    strobes.timerClear[TMR_CPU] = holdActive || cpuKick;
    strobes.timerCount[TMR_CPU] = !strobes.timerClear[TMR_CPU];

    strobes.holdLoad  = anyReq;
    strobes.holdDec   = holdActive && !anyReq;
    strobes.causeLoad = anyReq && idle;

    if (pinReq)        strobes.causeVal = CAUSE_PIN;
    else if (cmdReq)   strobes.causeVal = CAUSE_SPI_CMD;
    else if (spiWdReq) strobes.causeVal = CAUSE_SPI_WD;
    else if (cpuWdReq) strobes.causeVal = CAUSE_CPU_WD;
    else               strobes.causeVal = CAUSE_POWER;
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import reset_supervisor_pkg::*;
#(
  parameter int unsigned PIN_FILTER_CYCLES = 1000,
  parameter int unsigned SPI_WD_CYCLES     = 2650000,
  parameter int unsigned CPU_WD_CYCLES     = 6250000,
  parameter int unsigned PULSE_CYCLES      = 16
) (
  input  logic       clk,
  input  logic       supplyGood,
  input  logic       extResetN,
  input  logic       spiResetCmd,
  input  logic       spiValidOp,
  input  logic       cpuKick,
  input  logic       spiWdEnable,
  output logic       chipReset,
  output logic [2:0] resetCause
);
  ctrlStrobes_t          strobes;
  logic [NUM_TIMERS-1:0] timerAtLast;
  logic                  holdActive;

  reset_supervisor_ctrl ctrl_i (
    .extResetN  (extResetN),
    .spiResetCmd(spiResetCmd),
    .spiValidOp (spiValidOp),
    .cpuKick    (cpuKick),
    .spiWdEnable(spiWdEnable),
    .timerAtLast(timerAtLast),
    .holdActive (holdActive),
    .strobes    (strobes)
  );

  reset_supervisor_dp #(
    .PIN_FILTER_CYCLES(PIN_FILTER_CYCLES),
    .SPI_WD_CYCLES    (SPI_WD_CYCLES),
    .CPU_WD_CYCLES    (CPU_WD_CYCLES),
    .PULSE_CYCLES     (PULSE_CYCLES)
  ) dp_i (
    .clk        (clk),
    .supplyGood (supplyGood),
    .strobes    (strobes),
    .timerAtLast(timerAtLast),
    .holdActive (holdActive),
    .resetCause (resetCause)
  );

  assign chipReset = holdActive;
endmodule

// File: rtl/reset_supervisor_checker.sv
module reset_supervisor_checker (
  input logic       clk,
  input logic       supplyGood,
  input logic       extResetN,
  input logic       spiResetCmd,
  input logic       spiValidOp,
  input logic       cpuKick,
  input logic       spiWdEnable,
  input logic       chipReset,
  input logic [2:0] resetCause
);
  assert_cmd_resets_R4: assert property (@(posedge clk) disable iff (!supplyGood)
    (!chipReset && spiResetCmd) |=> chipReset);

  assert_cause_on_rise_R11: assert property (@(posedge clk) disable iff (!supplyGood)
    !$rose(chipReset) |-> $stable(resetCause));

  assert_cause_range_R11: assert property (@(posedge clk) disable iff (!supplyGood)
    resetCause <= 3'd4);

  assert_wd_off_R6: assert property (@(posedge clk) disable iff (!supplyGood)
    !spiWdEnable |=> !($rose(chipReset) && resetCause == 3'd3));

  assert_feed_blocks_R5: assert property (@(posedge clk) disable iff (!supplyGood)
    spiValidOp |=> !($rose(chipReset) && resetCause == 3'd3));

  assert_kick_blocks_R7: assert property (@(posedge clk) disable iff (!supplyGood)
    cpuKick |=> !($rose(chipReset) && resetCause == 3'd4));

  assert_pin_high_no_pin_cause_R2: assert property (@(posedge clk) disable iff (!supplyGood)
    extResetN |=> !($rose(chipReset) && resetCause == 3'd1));

  assert_pulse_min_R8: assert property (@(posedge clk) disable iff (!supplyGood)
    $rose(chipReset) |=> chipReset);
endmodule

bind reset_supervisor reset_supervisor_checker chk_i (
  .clk        (clk),
  .supplyGood (supplyGood),
  .extResetN  (extResetN),
  .spiResetCmd(spiResetCmd),
  .spiValidOp (spiValidOp),
  .cpuKick    (cpuKick),
  .spiWdEnable(spiWdEnable),
  .chipReset  (chipReset),
  .resetCause (resetCause)
);

// File: tb/reset_supervisor_tb_top.sv
`timescale 1ns/1ps
module reset_supervisor_tb_top;
  localparam int N = 4;
  localparam int S = 10;
  localparam int C = 16;
  localparam int P = 3;

  logic clk = 1'b0;
  logic supplyGood = 1'b0;
  logic extResetN = 1'b1;
  logic spiResetCmd = 1'b0;
  logic spiValidOp = 1'b0;
  logic cpuKick = 1'b0;
  logic spiWdEnable = 1'b0;
  logic chipReset;
  logic [2:0] resetCause;

  int errors = 0;
  int checks = 0;
  string phaseReq = "R1";
  bit autoKick = 1'b1;
  int kickPhase = 0;

  // behavioural reference state
  int mHold = P, mCause = 0, lowRun = 0, spiRun = 0, cpuRun = 0;

  always #10 clk = ~clk;

  reset_supervisor #(
    .PIN_FILTER_CYCLES(N), .SPI_WD_CYCLES(S),
    .CPU_WD_CYCLES(C), .PULSE_CYCLES(P)
  ) dut_i (
    .clk(clk), .supplyGood(supplyGood), .extResetN(extResetN),
    .spiResetCmd(spiResetCmd), .spiValidOp(spiValidOp), .cpuKick(cpuKick),
    .spiWdEnable(spiWdEnable), .chipReset(chipReset), .resetCause(resetCause)
  );

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic waitEdges(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  always @(negedge clk) begin
    kickPhase <= kickPhase + 1;
    cpuKick   <= autoKick && (kickPhase % 4 == 0);
  end

  // reference model, compared after every rising edge
  always begin
    @(posedge clk);
    if (!supplyGood) begin
      mHold = P; mCause = 0; lowRun = 0; spiRun = 0; cpuRun = 0;
    end else begin
      bit idle;
      idle = (mHold == 0);
      lowRun = extResetN ? 0 : lowRun + 1;
      if (!idle || !spiWdEnable || spiValidOp) spiRun = 0; else spiRun++;
      if (!idle || cpuKick) cpuRun = 0; else cpuRun++;
      if (lowRun >= N) begin
        if (idle) mCause = 1;
        mHold = P;
      end else if (!idle) mHold--;
      else if (spiResetCmd) begin mHold = P; mCause = 2; end
      else if (spiRun >= S) begin mHold = P; mCause = 3; end
      else if (cpuRun >= C) begin mHold = P; mCause = 4; end
    end
    #5;
    checkVal(phaseReq, "model chipReset", int'(chipReset), int'(mHold != 0));
    checkVal(phaseReq, "model resetCause", int'(resetCause), mCause);
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung in phase %s actual=running expected=done", phaseReq);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: power
    waitEdges(2);
    checkVal("R1", "chipReset in power loss", int'(chipReset), 1);
    checkVal("R1", "cause in power loss", int'(resetCause), 0);
    @(negedge clk) supplyGood = 1'b1;
    waitEdges(P - 1);
    checkVal("R1", "chipReset before P edges", int'(chipReset), 1);
    waitEdges(1);
    checkVal("R1", "chipReset after P edges", int'(chipReset), 0);

    // R2: short pin pulse filtered
    phaseReq = "R2";
    @(negedge clk) extResetN = 1'b0;
    waitEdges(N - 1);
    @(negedge clk) extResetN = 1'b1;
    waitEdges(3);
    checkVal("R2", "short pin pulse", int'(chipReset), 0);

    // R2/R3: qualified pin and hold
    @(negedge clk) extResetN = 1'b0;
    waitEdges(N - 1);
    checkVal("R2", "pin N-1 low edges", int'(chipReset), 0);
    waitEdges(1);
    checkVal("R2", "pin N low edges", int'(chipReset), 1);
    checkVal("R2", "pin cause", int'(resetCause), 1);
    phaseReq = "R3";
    waitEdges(6);
    checkVal("R3", "held while pin low", int'(chipReset), 1);
    @(negedge clk) extResetN = 1'b1;
    waitEdges(P - 1);
    checkVal("R3", "still high after release", int'(chipReset), 1);
    waitEdges(1);
    checkVal("R3", "low P edges after release", int'(chipReset), 0);

    // R4/R8: command, repeated during pulse
    phaseReq = "R4";
    @(negedge clk) spiResetCmd = 1'b1;
    waitEdges(1);
    checkVal("R4", "command reset", int'(chipReset), 1);
    checkVal("R4", "command cause", int'(resetCause), 2);
    @(negedge clk) spiResetCmd = 1'b1;
    @(negedge clk) spiResetCmd = 1'b0;
    phaseReq = "R8";
    waitEdges(1);
    checkVal("R8", "pulse edge P-1", int'(chipReset), 1);
    waitEdges(1);
    checkVal("R8", "pulse ends after P (R4 repeat ignored)", int'(chipReset), 0);

    // R6: disabled SPI watchdog
    phaseReq = "R6";
    waitEdges(S + 4);
    checkVal("R6", "no reset while disabled", int'(chipReset), 0);
    checkVal("R6", "cause kept", int'(resetCause), 2);

    // R5: fed then starved
    phaseReq = "R5";
    @(negedge clk) begin spiWdEnable = 1'b1; spiValidOp = 1'b1; end
    @(negedge clk) spiValidOp = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (4) @(negedge clk);
      spiValidOp = 1'b1;
      @(negedge clk) spiValidOp = 1'b0;
    end
    checkVal("R5", "fed watchdog silent", int'(chipReset), 0);
    waitEdges(S - 1);
    checkVal("R5", "S-1 unfed edges", int'(chipReset), 0);
    waitEdges(1);
    checkVal("R5", "S unfed edges reset", int'(chipReset), 1);
    checkVal("R5", "SPI watchdog cause", int'(resetCause), 3);

    // R9: restart from zero after pulse
    phaseReq = "R9";
    waitEdges(P + S - 1);
    checkVal("R9", "no early second reset", int'(chipReset), 0);
    waitEdges(1);
    checkVal("R9", "second reset at P+S", int'(chipReset), 1);
    @(negedge clk) spiWdEnable = 1'b0;
    waitEdges(P + 1);

    // R10: command beats SPI watchdog
    phaseReq = "R10";
    @(negedge clk) begin spiWdEnable = 1'b1; spiValidOp = 1'b1; end
    @(negedge clk) spiValidOp = 1'b0;
    repeat (S - 1) @(negedge clk);
    spiResetCmd = 1'b1;
    waitEdges(1);
    checkVal("R10", "command over SPI watchdog", int'(resetCause), 2);
    @(negedge clk) begin spiResetCmd = 1'b0; spiWdEnable = 1'b0; end
    waitEdges(P + 1);

    // R10: pin beats command
    @(negedge clk) extResetN = 1'b0;
    repeat (N - 1) @(negedge clk);
    spiResetCmd = 1'b1;
    waitEdges(1);
    checkVal("R10", "pin over command", int'(resetCause), 1);
    @(negedge clk) begin spiResetCmd = 1'b0; extResetN = 1'b1; end
    waitEdges(P + 1);

    // R11: pin qualifies inside a command pulse
    phaseReq = "R11";
    @(negedge clk) begin spiResetCmd = 1'b1; extResetN = 1'b0; end
    @(negedge clk) spiResetCmd = 1'b0;
    repeat (N + 2) @(negedge clk);
    extResetN = 1'b1;
    waitEdges(1);
    checkVal("R11", "pulse extended by pin", int'(chipReset), 1);
    waitEdges(P + 1);
    checkVal("R11", "cause kept as command", int'(resetCause), 2);
    checkVal("R11", "pulse finished", int'(chipReset), 0);

    // R7: processor watchdog
    phaseReq = "R7";
    @(negedge clk) autoKick = 1'b0;
    waitEdges(C + 3);
    checkVal("R7", "processor watchdog cause", int'(resetCause), 4);
    @(negedge clk) autoKick = 1'b1;
    waitEdges(P + 2);

    // R1/R11: power loss clears cause
    phaseReq = "R1";
    @(negedge clk) supplyGood = 1'b0;
    #1;
    checkVal("R1", "async reset on power loss", int'(chipReset), 1);
    checkVal("R11", "cause cleared by power", int'(resetCause), 0);
    waitEdges(2);
    @(negedge clk) supplyGood = 1'b1;
    waitEdges(P + 1);
    checkVal("R1", "running after power return", int'(chipReset), 0);
    checkVal("R11", "cause after power return", int'(resetCause), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule